// File: doc/BRIEF.md
# Split Flag Source Tracker

This block sits beside the issue stage of an out-of-order core and follows where the arithmetic status flags came from. The flags fall into two groups: carry, and everything else. A micro-op that writes only some of the groups leaves the others pointing at an older producer. When a later micro-op reads a group that the most recent flag writer did not produce, the groups must be joined before the reader can go. The block applies one of three penalty schemes to that join and tells the issue stage, cycle by cycle, whether to send the held micro-op, hold it, or slip in a merge micro-op ahead of it.

Each cycle the front end presents one micro-op descriptor. It carries a valid bit, a flag write mask, a flag read mask and a marker for a variable-count shift whose count is zero. The descriptor stays stable while `stall_o` is high. It is consumed in the cycle `issue_o` is high. A two-bit policy input selects the penalty scheme. Flag values, execution and decode are handled elsewhere.

Top module: `flag_split_tracker`

## Requirements
- R1: After reset the flag groups share one source and no penalty is pending. `stall_o` and `merge_req_o` are low, and a valid micro-op with any masks issues in the same cycle.
- R2: Mask bit 0 is the carry group and bit 1 is the group of other arithmetic flags. An increment-style micro-op (write mask 2'b10) leaves carry owned by its earlier producer, so a later carry reader is penalised under policies 1, 2 and 3.
- R3: A micro-op whose read mask names only groups produced by the most recent flag writer issues in its first cycle with `stall_o` low.
- R4: A full write (mask 2'b11) after a partial write re-joins the groups. Any reader after it issues with no penalty.
- R5: Under policy 1, a reader that needs a group not produced by the most recent flag writer sees `stall_o` high for STALL_CYC cycles (default 7) and issues in the next cycle. After that the groups share one source.
- R6: Under policy 2 or 3, the same reader raises `merge_req_o` for exactly one cycle with `stall_o` high and issues in the following cycle. The groups then share one source.
- R7: Under policy 0 no reader is ever penalised. A partial writer (write mask neither 0 nor all ones) is held until PROD_LAT cycles (default 3) have passed since the issue of the previous flag writer.
- R8: A micro-op with the zero-count shift marker set is treated as reading both groups and writing both groups, whatever its masks say.
- R9: `issue_o` is high only when `uop_valid_i` is high and `stall_o` is low.
- R10: `merge_req_o` never rises under policy 0 or policy 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | 0 false dependency, 1 fixed stall, 2 or 3 merge micro-op |
| uop_valid_i | input | 1 | Descriptor present |
| uop_wr_mask_i | input | N_GRP | Flag groups written (bit 0 carry) |
| uop_rd_mask_i | input | N_GRP | Flag groups read (bit 0 carry) |
| uop_shz_i | input | 1 | Variable shift with a zero count |
| issue_o | output | 1 | Descriptor accepted this cycle |
| stall_o | output | 1 | Descriptor must be held |
| merge_req_o | output | 1 | Insert one merge micro-op this cycle |

## Verification
The bench chains an increment-style writer into carry readers, other-group readers, full writers and zero-count shifts under every policy, and compares all three outputs against a reference model on every cycle.

Each wrong design shows up in a specific way:
- A tracker that charged a penalty for reading only fresh groups would stall after an increment followed by an other-flags reader.
- One that forgot to re-join on a full write would stall the carry reader that follows it.
- An off-by-one in the stall counter gives six or eight stall cycles instead of seven.
- A merge that lasts more than one cycle, or that fires under the wrong policy, shows up on `merge_req_o`.
- A false-dependency path that ignores producer latency lets the increment issue right behind the previous writer.

// File: rtl/fst_pkg.sv
package fst_pkg;
  typedef enum logic [1:0] {
    POL_FDEP      = 2'd0,
    POL_STALL     = 2'd1,
    POL_MERGE     = 2'd2,
    POL_MERGE_ALT = 2'd3
  } pol_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_e;
endpackage

// File: rtl/fst_hazard.sv
module fst_hazard #(
  parameter int N_GRP = 2
) (
  input  logic             valid_i,
  input  logic [N_GRP-1:0] wr_mask_i,
  input  logic [N_GRP-1:0] rd_mask_i,
  input  logic             shz_i,
  input  logic [N_GRP-1:0] stale_i,
  output logic [N_GRP-1:0] wr_eff_o,
  output logic             writer_o,
  output logic             partial_o,
  output logic             need_merge_o
);
  logic [N_GRP-1:0] rd_eff;

  // zero-count shift keeps old flags: reads all, writes all
  assign wr_eff_o     = shz_i ? {N_GRP{1'b1}} : wr_mask_i;
  assign rd_eff       = shz_i ? {N_GRP{1'b1}} : rd_mask_i;
  assign writer_o     = |wr_eff_o;
  assign partial_o    = writer_o & ~(&wr_eff_o);
  assign need_merge_o = valid_i & (|(rd_eff & stale_i));
endmodule

// File: rtl/fst_flag_state.sv
module fst_flag_state #(
  parameter int N_GRP    = 2,
  parameter int PROD_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             commit_i,
  input  logic             serialize_i,
  input  logic [N_GRP-1:0] wr_eff_i,
  output logic [N_GRP-1:0] stale_o,
  output logic             busy_o
);
  localparam int BUSY_W = (PROD_LAT > 2) ? $clog2(PROD_LAT) : 1;

  logic [N_GRP-1:0] stale_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    // stale: group not produced by the most recent flag writer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stale_q[g] <= 1'b0;
      else if (clear_i)  stale_q[g] <= 1'b0;
      else if (commit_i) stale_q[g] <= serialize_i ? 1'b0 : ~wr_eff_i[g];
    end
  end
  assign stale_o = stale_q;

  if (PROD_LAT > 1) begin : g_busy
    logic [BUSY_W-1:0] busy_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              busy_q <= '0;
      else if (commit_i)        busy_q <= BUSY_W'(PROD_LAT - 1);
      else if (busy_q != '0)    busy_q <= busy_q - 1'b1;
    end
    assign busy_o = (busy_q != '0);
  end else begin : g_nobusy
    assign busy_o = 1'b0;
  end
endmodule

// File: rtl/fst_penalty_seq.sv
module fst_penalty_seq
  import fst_pkg::*;
#(
  parameter int STALL_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic wait_o,
  output logic done_o
);
  localparam int CNT_W = (STALL_CYC > 2) ? $clog2(STALL_CYC) : 1;

  seq_e             st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start_i) begin
          st_q  <= SEQ_WAIT;
          cnt_q <= CNT_W'(STALL_CYC - 1);
        end
        SEQ_WAIT: begin
          if (cnt_q == CNT_W'(1)) st_q <= SEQ_IDLE;
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign wait_o = (st_q == SEQ_WAIT);
  assign done_o = wait_o & (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flag_split_tracker.sv
module flag_split_tracker
  import fst_pkg::*;
#(
  parameter int N_GRP     = 2,
  parameter int STALL_CYC = 7,
  parameter int PROD_LAT  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       policy_i,
  input  logic             uop_valid_i,
  input  logic [N_GRP-1:0] uop_wr_mask_i,
  input  logic [N_GRP-1:0] uop_rd_mask_i,
  input  logic             uop_shz_i,
  output logic             issue_o,
  output logic             stall_o,
  output logic             merge_req_o
);
  localparam bit SHORT_STALL = (STALL_CYC < 2);

  pol_e             pol;
  logic             pol_fdep, pol_merge;
  logic [N_GRP-1:0] wr_eff, stale;
  logic             writer, partial, need_merge, busy;
  logic             in_wait, wait_done, start_wait, clear_split, commit;

  assign pol       = pol_e'(policy_i);
  assign pol_fdep  = (pol == POL_FDEP);
  assign pol_merge = (pol == POL_MERGE) | (pol == POL_MERGE_ALT);

  fst_hazard #(.N_GRP(N_GRP)) u_hazard (
    .valid_i      (uop_valid_i),
    .wr_mask_i    (uop_wr_mask_i),
    .rd_mask_i    (uop_rd_mask_i),
    .shz_i        (uop_shz_i),
    .stale_i      (stale),
    .wr_eff_o     (wr_eff),
    .writer_o     (writer),
    .partial_o    (partial),
    .need_merge_o (need_merge)
  );

  fst_flag_state #(.N_GRP(N_GRP), .PROD_LAT(PROD_LAT)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_split),
    .commit_i    (commit),
    .serialize_i (pol_fdep),
    .wr_eff_i    (wr_eff),
    .stale_o     (stale),
    .busy_o      (busy)
  );

  fst_penalty_seq #(.STALL_CYC(STALL_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_wait),
    .wait_o  (in_wait),
    .done_o  (wait_done)
  );

  always_comb begin
    issue_o     = 1'b0;
    stall_o     = 1'b0;
    merge_req_o = 1'b0;
    start_wait  = 1'b0;
    clear_split = 1'b0;
    if (in_wait) begin
      stall_o     = 1'b1;
      clear_split = wait_done;
    end else if (uop_valid_i) begin
      if (pol_fdep) begin
        // partial writer serializes behind previous flag producer
        if (partial && busy) stall_o = 1'b1;
        else                 issue_o = 1'b1;
      end else if (need_merge) begin
        stall_o = 1'b1;
        if (pol_merge) begin
          merge_req_o = 1'b1;
          clear_split = 1'b1;
        end else if (SHORT_STALL) begin
          clear_split = 1'b1;
        end else begin
          start_wait = 1'b1;
        end
      end else begin
        issue_o = 1'b1;
      end
    end
  end

  assign commit = issue_o & writer;
endmodule

// File: rtl/fst_chk.sv
module fst_chk #(
  parameter int STALL_CYC = 7
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] policy_i,
  input logic       uop_valid_i,
  input logic       issue_o,
  input logic       stall_o,
  input logic       merge_req_o
);
  localparam int RUN_W = $clog2(STALL_CYC + 2) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (!stall_o)            run_q <= '0;
    else if (run_q != '1)         run_q <= run_q + 1'b1;
  end

  a_r9_no_issue_while_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_o && stall_o));

  a_r9_issue_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> uop_valid_i);

  a_r6_merge_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_req_o |=> !merge_req_o);

  a_r6_issue_after_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (merge_req_o && uop_valid_i) |=> issue_o);

  a_r10_merge_policy_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_req_o |-> (policy_i[1] && stall_o));

  a_r5_stall_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd1 && $fell(stall_o)) |-> (run_q == RUN_W'(STALL_CYC)));
endmodule

bind flag_split_tracker fst_chk #(.STALL_CYC(STALL_CYC)) u_fst_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .policy_i    (policy_i),
  .uop_valid_i (uop_valid_i),
  .issue_o     (issue_o),
  .stall_o     (stall_o),
  .merge_req_o (merge_req_o)
);

// File: tb/flag_split_tracker_bench.sv
module flag_split_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STALL_CYC  = 7;
  localparam int PROD_LAT   = 3;
  localparam int WD_CYCLES  = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] policy_i = 2'd1;
  logic       uop_valid_i = 1'b0;
  logic [1:0] uop_wr_mask_i = 2'b00;
  logic [1:0] uop_rd_mask_i = 2'b00;
  logic       uop_shz_i = 1'b0;
  logic       issue_o, stall_o, merge_req_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // reference model: producer id per group
  int src[2];
  int latest = 0;
  int pen    = 0;
  int busy   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flag_split_tracker #(.N_GRP(2), .STALL_CYC(STALL_CYC), .PROD_LAT(PROD_LAT)) u_flag_split_tracker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .policy_i      (policy_i),
    .uop_valid_i   (uop_valid_i),
    .uop_wr_mask_i (uop_wr_mask_i),
    .uop_rd_mask_i (uop_rd_mask_i),
    .uop_shz_i     (uop_shz_i),
    .issue_o       (issue_o),
    .stall_o       (stall_o),
    .merge_req_o   (merge_req_o)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_CYCLES) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", WD_CYCLES);
      finish_run();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void unify();
    src[0] = latest;
    src[1] = latest;
  endfunction

  function automatic void m_eval(output bit ei, output bit es, output bit em);
    logic [1:0] we, re;
    bit need;
    ei = 0; es = 0; em = 0;
    we = uop_shz_i ? 2'b11 : uop_wr_mask_i;
    re = uop_shz_i ? 2'b11 : uop_rd_mask_i;
    if (pen > 0) es = 1;
    else if (uop_valid_i) begin
      if (policy_i == 2'd0) begin
        if (we != 2'b00 && we != 2'b11 && busy > 0) es = 1;
        else ei = 1;
      end else begin
        need = 0;
        for (int g = 0; g < 2; g++) if (re[g] && src[g] != latest) need = 1;
        if (need) begin
          es = 1;
          em = (policy_i >= 2'd2);
        end else ei = 1;
      end
    end
  endfunction

  function automatic void m_update(input bit ei, input bit es);
    logic [1:0] we;
    bit bset = 0;
    we = uop_shz_i ? 2'b11 : uop_wr_mask_i;
    if (pen > 0) begin
      pen--;
      if (pen == 0) unify();
    end else if (uop_valid_i && es && policy_i != 2'd0) begin
      if (policy_i >= 2'd2) unify();
      else begin
        pen = STALL_CYC - 1;
        if (pen == 0) unify();
      end
    end
    if (ei && we != 2'b00) begin
      latest++;
      for (int g = 0; g < 2; g++) if (we[g]) src[g] = latest;
      if (policy_i == 2'd0) unify();
      busy = PROD_LAT - 1;
      bset = 1;
    end
    if (!bset && busy > 0) busy--;
  endfunction

  // compare outputs mid-cycle, then advance model across the edge
  task automatic cycle_step(input string tag, output bit ei, output bit es, output bit em);
    #1;
    m_eval(ei, es, em);
    check({tag, " issue_o"}, int'(issue_o), int'(ei));
    check({tag, " stall_o"}, int'(stall_o), int'(es));
    check({tag, " merge_req_o"}, int'(merge_req_o), int'(em));
    @(posedge clk_i);
    m_update(ei, es);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n, input string tag);
    bit ei, es, em;
    uop_valid_i = 1'b0;
    for (int i = 0; i < n; i++) cycle_step(tag, ei, es, em);
  endtask

  task automatic run_uop(input logic [1:0] pol, input logic [1:0] wr, input logic [1:0] rd,
                         input logic shz, input string tag, output int stalls, output int merges);
    bit ei, es, em;
    stalls = 0;
    merges = 0;
    policy_i = pol;
    uop_valid_i = 1'b1;
    uop_wr_mask_i = wr;
    uop_rd_mask_i = rd;
    uop_shz_i = shz;
    for (int k = 0; k < 40; k++) begin
      cycle_step(tag, ei, es, em);
      stalls += int'(es);
      merges += int'(em);
      if (ei) break;
    end
    uop_valid_i = 1'b0;
    uop_shz_i = 1'b0;
  endtask

  initial begin
    int s, m;
    src[0] = 0;
    src[1] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1: reset state
    check("R1 stall_o after reset", int'(stall_o), 0);
    check("R1 merge_req_o after reset", int'(merge_req_o), 0);
    @(negedge clk_i);
    run_uop(2'd1, 2'b01, 2'b11, 1'b0, "R1", s, m);
    check("R1 stalls of first reader", s, 0);

    // stall policy
    idle(4, "R5 idle");
    run_uop(2'd1, 2'b11, 2'b00, 1'b0, "R3 full write", s, m);
    run_uop(2'd1, 2'b00, 2'b10, 1'b0, "R3 fresh read", s, m);
    check("R3 stalls fresh read", s, 0);
    run_uop(2'd1, 2'b10, 2'b00, 1'b0, "R2 inc", s, m);
    run_uop(2'd1, 2'b11, 2'b01, 1'b0, "R5 carry read", s, m);
    check("R5 stall cycles", s, STALL_CYC);
    check("R10 no merge under policy 1", m, 0);
    run_uop(2'd1, 2'b00, 2'b11, 1'b0, "R5 unified read", s, m);
    check("R5 stalls after join", s, 0);

    // R2 / R3: other-group read after increment is free
    idle(2, "R2 idle");
    run_uop(2'd1, 2'b10, 2'b00, 1'b0, "R2 inc", s, m);
    run_uop(2'd1, 2'b00, 2'b10, 1'b0, "R3 other read", s, m);
    check("R3 other read after inc", s, 0);
    run_uop(2'd1, 2'b00, 2'b01, 1'b0, "R2 carry read", s, m);
    check("R2 carry keeps old source", s, STALL_CYC);

    // R4: full write rejoins
    run_uop(2'd1, 2'b10, 2'b00, 1'b0, "R4 inc", s, m);
    run_uop(2'd1, 2'b11, 2'b00, 1'b0, "R4 full write", s, m);
    run_uop(2'd1, 2'b00, 2'b01, 1'b0, "R4 carry read", s, m);
    check("R4 carry read after full write", s, 0);

    // merge policy
    for (int p = 2; p <= 3; p++) begin
      idle(2, "R6 idle");
      run_uop(2'(p), 2'b10, 2'b00, 1'b0, "R6 inc", s, m);
      run_uop(2'(p), 2'b11, 2'b01, 1'b0, "R6 carry read", s, m);
      check("R6 merge pulses", m, 1);
      check("R6 stall cycles", s, 1);
      run_uop(2'(p), 2'b00, 2'b01, 1'b0, "R6 reread", s, m);
      check("R6 no penalty after merge", s + m, 0);
    end

    // false-dependency policy
    idle(4, "R7 idle");
    run_uop(2'd0, 2'b11, 2'b00, 1'b0, "R7 full write", s, m);
    run_uop(2'd0, 2'b10, 2'b00, 1'b0, "R7 inc", s, m);
    check("R7 partial writer wait", s, PROD_LAT - 1);
    run_uop(2'd0, 2'b00, 2'b01, 1'b0, "R7 carry read", s, m);
    check("R7 reader stalls", s, 0);
    check("R10 no merge under policy 0", m, 0);
    run_uop(2'd0, 2'b11, 2'b00, 1'b0, "R7 full after full", s, m);
    run_uop(2'd0, 2'b11, 2'b00, 1'b0, "R7 full back to back", s, m);
    check("R7 full writer no wait", s, 0);

    // zero-count shift
    idle(4, "R8 idle");
    run_uop(2'd1, 2'b10, 2'b00, 1'b0, "R8 inc", s, m);
    run_uop(2'd1, 2'b00, 2'b00, 1'b1, "R8 shift zero", s, m);
    check("R8 shift zero stalls", s, STALL_CYC);
    run_uop(2'd1, 2'b00, 2'b01, 1'b0, "R8 carry read", s, m);
    check("R8 carry read after shift", s, 0);
    run_uop(2'd2, 2'b10, 2'b00, 1'b0, "R8 inc", s, m);
    run_uop(2'd2, 2'b00, 2'b00, 1'b1, "R8 shift zero merge", s, m);
    check("R8 shift zero merge", m, 1);
    run_uop(2'd2, 2'b10, 2'b00, 1'b1, "R8 shift after shift", s, m);
    check("R8 shift is full writer", s, 0);

    // R9: no issue without valid
    idle(3, "R9 idle");
    finish_run();
  end
endmodule